// File: doc/BRIEF.md
# Serial DAC Register Interface

This block sits between a three-wire serial host link and the core of an 18-bit precision converter. The link has a frame strobe that is active low, a serial clock and a serial data input. The block samples all three pins in the system clock domain and collects 24-bit command words. It decodes each word into a read or a write of one small register. The registers hold the converter code, a control word and a fallback ("clear") code. A fourth, write-only register fires one-cycle actions.

The converter code is always presented in parallel to the core. A one-cycle strobe marks every change to it. A read command loads a reply word into a transmit shifter, and the host collects that reply on a serial data output during the frame that follows. Normally that next frame is a no-operation. The system clock must run at least four times faster than the serial clock, and the serial pins pass through two synchronizer flops.

Top module: `sdac_regif`

## Requirements
- R1: While reset is asserted and after reset, the DAC code, the control register, the clear register, the transmit shifter (`sdo_o`), `dac_valid_o` and `load_o` are all zero.
- R2: A write frame to address 001 (bit 23 = 0, bits 22:20 = 001) sets `dac_code_o` to data bits 19:2 and ignores data bits 1:0. The new code and a `dac_valid_o` pulse of exactly one cycle appear together on the fourth rising `clk` edge after `sync_n_i` goes high. The code never changes without that pulse.
- R3: A write to address 010 loads the 20-bit data field into the control register, which drives `ctrl_o`. A write to address 011 loads the clear register.
- R4: A frame with address 000 changes no register, whatever its read/write bit and data field hold.
- R5: A frame is committed only if `sdi_i` was sampled on exactly 24 falling `sclk_i` edges while `sync_n_i` was low. Shorter and longer frames change no register.
- R6: After a committed read frame (bit 23 = 1), the next frame shifts out MSB first on `sdo_o` the word {1, address, data}. Bit 23 is present before the first falling `sclk_i` edge, and each falling edge advances one bit. A read of 001 returns {code, 00}, a read of 010 returns the control register and a read of 011 returns the clear register.
- R7: A read of address 000, 100, 101, 110 or 111 returns zero in data bits 19:0 and still echoes bit 23 and the address.
- R8: A write to address 100 stores nothing. Data bit 0 set gives a one-cycle `load_o` pulse. Data bit 1 set copies bits 19:2 of the clear register into the DAC code with a `dac_valid_o` pulse. Both act with the latency given in R2.
- R9: Write frames to addresses 101, 110 and 111 change no register.
- R10: Toggles of `sclk_i` while `sync_n_i` is high neither shift data nor count toward the 24-bit frame length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n_i | input | 1 | Frame strobe, low during a frame |
| sclk_i | input | 1 | Serial clock; data is sampled on its falling edge |
| sdi_i | input | 1 | Serial data in, MSB first |
| sdo_o | output | 1 | Serial reply data out, MSB first |
| dac_code_o | output | 18 | Parallel converter code |
| dac_valid_o | output | 1 | One-cycle strobe when the code is updated |
| load_o | output | 1 | One-cycle load strobe from the software control register |
| ctrl_o | output | 20 | Control register contents |

## Verification
The checker assumes that the host keeps `sdi_i` stable for several system clocks around each falling `sclk_i` edge. It also assumes that every serial level lasts at least two system clocks, and that successive frames are separated by enough idle cycles for a commit to finish before the next frame starts. Under those assumptions, update strobes cannot come back to back, and the reply shifter moves only after a sampled edge or a read commit. The bench holds each serial clock phase for four system clocks, changes data only while the serial clock is high, and leaves ten idle cycles after every frame.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int FRAME_W       = 24;
  localparam int ADDR_W        = 3;
  localparam int DATA_W        = FRAME_W - 1 - ADDR_W;
  localparam int CODE_W        = 18;
  localparam int PAD_W         = DATA_W - CODE_W;
  localparam int SWC_LOAD_BIT  = 0;
  localparam int SWC_CLEAR_BIT = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_NOP  = 3'd0,
    REG_DAC  = 3'd1,
    REG_CTRL = 3'd2,
    REG_CLR  = 3'd3,
    REG_SWC  = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [STAGES:0][W-1:0] stg_q;
  logic [STAGES:0][W-1:0] stg_d;
  logic [W-1:0]           prev;

  assign stg_d[0] = pin_i;
  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    assign stg_d[g] = stg_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {(STAGES+1){RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign prev   = stg_q[STAGES];
  assign rise_o = lvl_o & ~prev;
  assign fall_o = ~lvl_o & prev;
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
  import sdac_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_lvl_i,
  input  logic   sync_fall_i,
  input  logic   sync_rise_i,
  input  logic   sclk_fall_i,
  input  logic   sdi_i,
  output logic   cmd_vld_o,
  output frame_t cmd_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               vld_q, vld_d;
  logic               sh_en, cnt_en;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    sh_en  = 1'b0;
    cnt_en = 1'b0;
    vld_d  = 1'b0;
    if (sync_fall_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (sclk_fall_i && !sync_lvl_i) begin
      sh_d  = {sh_q[FRAME_W-2:0], sdi_i};
      sh_en = 1'b1;
      if (cnt_q != CNT_MAX) begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
    end
    if (sync_rise_i) vld_d = (cnt_q == CNT_FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign cmd_vld_o = vld_q;
  assign cmd_o     = frame_t'(sh_q);
endmodule

// File: rtl/sdac_regfile.sv
module sdac_regfile
  import sdac_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_vld_i,
  input  frame_t             cmd_i,
  output logic [CODE_W-1:0]  dac_code_o,
  output logic               dac_valid_o,
  output logic               load_o,
  output logic [DATA_W-1:0]  ctrl_o,
  output logic               rd_load_o,
  output logic [FRAME_W-1:0] rd_word_o
);
  logic [CODE_W-1:0]  dac_q, dac_d;
  logic [DATA_W-1:0]  ctrl_q, clr_q;
  logic               dac_en, ctrl_en, clr_en;
  logic               valid_q, valid_d, load_q, load_d;
  logic               rdld_q, rdld_d;
  logic [FRAME_W-1:0] rdw_q, rdw_d;
  logic [DATA_W-1:0]  rd_data;
  logic               wr;

  assign wr = cmd_vld_i && !cmd_i.rd;

  always_comb begin
    dac_d   = dac_q;
    dac_en  = 1'b0;
    ctrl_en = 1'b0;
    clr_en  = 1'b0;
    valid_d = 1'b0;
    load_d  = 1'b0;
    if (wr) begin
      case (cmd_i.addr)
        REG_DAC: begin
          dac_d   = cmd_i.data[DATA_W-1:PAD_W];
          dac_en  = 1'b1;
          valid_d = 1'b1;
        end
        REG_CTRL: ctrl_en = 1'b1;
        REG_CLR:  clr_en  = 1'b1;
        REG_SWC: begin
          load_d = cmd_i.data[SWC_LOAD_BIT];
          if (cmd_i.data[SWC_CLEAR_BIT]) begin
            dac_d   = clr_q[DATA_W-1:PAD_W];
            dac_en  = 1'b1;
            valid_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cmd_i.addr)
      REG_DAC:  rd_data = {dac_q, {PAD_W{1'b0}}};
      REG_CTRL: rd_data = ctrl_q;
      REG_CLR:  rd_data = clr_q;
      default:  rd_data = '0;
    endcase
    rdld_d = cmd_vld_i && cmd_i.rd;
    rdw_d  = {1'b1, cmd_i.addr, rd_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dac_q <= '0;
    else if (dac_en) dac_q <= dac_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= cmd_i.data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      clr_q <= '0;
    else if (clr_en) clr_q <= cmd_i.data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      load_q  <= 1'b0;
      rdld_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      load_q  <= load_d;
      rdld_q  <= rdld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdw_q <= '0;
    else if (rdld_d) rdw_q <= rdw_d;
  end

  assign dac_code_o  = dac_q;
  assign dac_valid_o = valid_q;
  assign load_o      = load_q;
  assign ctrl_o      = ctrl_q;
  assign rd_load_o   = rdld_q;
  assign rd_word_o   = rdw_q;
endmodule

// File: rtl/sdac_tx_shift.sv
module sdac_tx_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  output logic         sdo_o
);
  logic [W-1:0] tx_q, tx_d;
  logic         tx_en;

  always_comb begin
    tx_d  = tx_q;
    tx_en = 1'b0;
    if (load_i) begin
      tx_d  = word_i;
      tx_en = 1'b1;
    end else if (shift_i) begin
      tx_d  = {tx_q[W-2:0], 1'b0};
      tx_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= '0;
    else if (tx_en) tx_q <= tx_d;
  end

  assign sdo_o = tx_q[W-1];
endmodule

// File: rtl/sdac_regif.sv
module sdac_regif
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              dac_valid_o,
  output logic              load_o,
  output logic [DATA_W-1:0] ctrl_o
);
  localparam int PIN_N   = 3;
  localparam int P_SYNC  = 0;
  localparam int P_SCLK  = 1;
  localparam int P_SDI   = 2;
  localparam logic [PIN_N-1:0] PIN_RST = PIN_N'(1) << P_SYNC;

  logic                rst_q1, rst_sync_n;
  logic [PIN_N-1:0]    pin_raw, pin_lvl, pin_rise, pin_fall;
  logic                sync_lvl, sync_rise, sync_fall, sclk_fall, shift_en;
  logic                cmd_vld;
  frame_t              cmd;
  logic                rd_load;
  logic [FRAME_W-1:0]  rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  assign pin_raw[P_SYNC] = sync_n_i;
  assign pin_raw[P_SCLK] = sclk_i;
  assign pin_raw[P_SDI]  = sdi_i;

  sdac_pin_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_pins (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_i  (pin_raw),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign sync_lvl  = pin_lvl[P_SYNC];
  assign sync_rise = pin_rise[P_SYNC];
  assign sync_fall = pin_fall[P_SYNC];
  assign sclk_fall = pin_fall[P_SCLK];
  assign shift_en  = sclk_fall && !sync_lvl;

  sdac_frame_rx u_rx (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sync_lvl_i  (sync_lvl),
    .sync_fall_i (sync_fall),
    .sync_rise_i (sync_rise),
    .sclk_fall_i (sclk_fall),
    .sdi_i       (pin_lvl[P_SDI]),
    .cmd_vld_o   (cmd_vld),
    .cmd_o       (cmd)
  );

  sdac_regfile u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cmd_vld_i   (cmd_vld),
    .cmd_i       (cmd),
    .dac_code_o  (dac_code_o),
    .dac_valid_o (dac_valid_o),
    .load_o      (load_o),
    .ctrl_o      (ctrl_o),
    .rd_load_o   (rd_load),
    .rd_word_o   (rd_word)
  );

  sdac_tx_shift #(.W(FRAME_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_i  (rd_load),
    .word_i  (rd_word),
    .shift_i (shift_en),
    .sdo_o   (sdo_o)
  );
endmodule

// File: rtl/sdac_regif_chk.sv
module sdac_regif_chk
  import sdac_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_valid,
  input logic              load,
  input logic [DATA_W-1:0] ctrl,
  input logic              sdo,
  input logic              cmd_vld,
  input logic              rd_load,
  input logic              shift_en
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid); // R2
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_valid |-> $stable(dac_code)); // R2
  AST_VALID_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |-> $past(cmd_vld)); // R5
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load); // R8
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_vld) |-> $stable(ctrl)); // R4
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(shift_en) && !$past(rd_load)) |-> $stable(sdo)); // R6
endmodule

bind sdac_regif sdac_regif_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .dac_code  (dac_code_o),
  .dac_valid (dac_valid_o),
  .load      (load_o),
  .ctrl      (ctrl_o),
  .sdo       (sdo_o),
  .cmd_vld   (cmd_vld),
  .rd_load   (rd_load),
  .shift_en  (shift_en)
);

// File: tb/sdac_regif_test.sv
module sdac_regif_test;
  logic        clk;
  logic        rst_n;
  logic        sync_n, sclk, sdi;
  logic        sdo;
  logic [17:0] code;
  logic        valid, load;
  logic [19:0] ctrl;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  cmp_on  = 0;
  bit  done    = 0;
  longint cyc  = 0;

  logic [17:0] m_code;
  logic [19:0] m_ctrl, m_clr;
  logic [23:0] m_tx;
  bit          m_valid, m_load;

  typedef struct { longint due; logic [23:0] w; } ev_t;
  ev_t evq[$];

  sdac_regif uut (
    .clk(clk), .rst_n(rst_n), .sync_n_i(sync_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .dac_code_o(code), .dac_valid_o(valid), .load_o(load), .ctrl_o(ctrl)
  );

  initial clk = 0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic apply(input logic [23:0] w);
    logic [2:0]  a;
    logic [19:0] d;
    a = w[22:20];
    d = w[19:0];
    if (!w[23]) begin
      case (a)
        3'd1: begin m_code = d[19:2]; m_valid = 1; end
        3'd2: m_ctrl = d;
        3'd3: m_clr = d;
        3'd4: begin
          if (d[0]) m_load = 1;
          if (d[1]) begin m_code = m_clr[19:2]; m_valid = 1; end
        end
        default: ;
      endcase
    end else begin
      case (a)
        3'd1: m_tx = {1'b1, a, m_code, 2'b00};
        3'd2: m_tx = {1'b1, a, m_ctrl};
        3'd3: m_tx = {1'b1, a, m_clr};
        default: m_tx = {1'b1, a, 20'h0};
      endcase
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (cmp_on && !done) begin
      m_valid = 0;
      m_load  = 0;
      while (evq.size() > 0 && evq[0].due == cyc) begin
        apply(evq[0].w);
        void'(evq.pop_front());
      end
      chk("R2 code", {14'h0, code}, {14'h0, m_code});
      chk("R2 valid", {31'h0, valid}, {31'h0, m_valid});
      chk("R3 ctrl", {12'h0, ctrl}, {12'h0, m_ctrl});
      chk("R8 load", {31'h0, load}, {31'h0, m_load});
    end
  end

  task automatic frame(input logic [23:0] w, input int nbits, input string req);
    logic [23:0] cap;
    logic        got, exp;
    cap = m_tx;
    @(negedge clk) sync_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi  = (i < 24) ? w[23-i] : 1'b0;
      sclk = 1;
      repeat (4) @(negedge clk);
      got = sdo;
      exp = (i < 24) ? cap[23-i] : 1'b0;
      chk(req, {31'h0, got}, {31'h0, exp});
      sclk = 0;
      repeat (4) @(negedge clk);
    end
    m_tx = (nbits >= 24) ? 24'h0 : (cap << nbits);
    sync_n = 1;
    if (nbits == 24) evq.push_back('{cyc + 4, w});
    repeat (10) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; sync_n = 1; sclk = 0; sdi = 0;
    m_code = 0; m_ctrl = 0; m_clr = 0; m_tx = 0; m_valid = 0; m_load = 0;
    repeat (3) @(negedge clk);
    chk("R1 code in reset", {14'h0, code}, 32'h0);
    chk("R1 sdo in reset", {31'h0, sdo}, 32'h0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 code", {14'h0, code}, 32'h0);
    chk("R1 ctrl", {12'h0, ctrl}, 32'h0);
    chk("R1 valid", {31'h0, valid}, 32'h0);
    cmp_on = 1;

    frame(24'h1ABCDF, 24, "R6 idle sdo");
    chk("R2 low bits dropped", {14'h0, code}, 32'h2AF37);
    frame(24'h1FFFFC, 24, "R6 idle sdo");
    chk("R2 all ones", {14'h0, code}, 32'h3FFFF);
    frame(24'h212345, 24, "R6 idle sdo");
    chk("R3 ctrl write", {12'h0, ctrl}, 32'h12345);
    frame(24'h35A5A4, 24, "R6 idle sdo");
    frame(24'h800000 | 24'h200000, 24, "R6 idle sdo");
    frame(24'h000000, 24, "R6 ctrl readback");
    frame(24'hB00000, 24, "R6 idle sdo");
    frame(24'h000000, 24, "R3 clr readback");
    frame(24'h900000, 24, "R6 idle sdo");
    frame(24'h0FFFFF, 24, "R6 dac readback");
    chk("R4 nop keeps code", {14'h0, code}, 32'h3FFFF);
    frame(24'h8FFFFF, 24, "R4 nop read");
    frame(24'h000000, 24, "R7 nop read zero data");

    frame(24'h100004, 23, "R5 short frame sdo");
    chk("R5 short frame discarded", {14'h0, code}, 32'h3FFFF);
    frame(24'h100004, 25, "R5 long frame sdo");
    chk("R5 long frame discarded", {14'h0, code}, 32'h3FFFF);

    frame(24'hC00000, 24, "R6 idle sdo");
    frame(24'h000000, 24, "R7 read swctl zero");
    frame(24'hF00000, 24, "R6 idle sdo");
    frame(24'h000000, 24, "R7 read 111 zero");

    frame(24'h5FFFFF, 24, "R9 write 101");
    frame(24'h7FFFFF, 24, "R9 write 111");
    chk("R9 code unchanged", {14'h0, code}, 32'h3FFFF);
    chk("R9 ctrl unchanged", {12'h0, ctrl}, 32'h12345);
    frame(24'hB00000, 24, "R6 idle sdo");
    frame(24'h000000, 24, "R9 clr unchanged readback");

    frame(24'h400002, 24, "R8 clear");
    chk("R8 clear copies clearcode", {14'h0, code}, 32'h16969);
    frame(24'h400001, 24, "R8 load");
    frame(24'h400003, 24, "R8 load and clear");
    frame(24'hC00000, 24, "R8 swctl read");
    frame(24'h000000, 24, "R8 swctl write-only readback");

    for (int k = 0; k < 5; k++) begin
      @(negedge clk) sclk = 1; sdi = 1;
      repeat (3) @(negedge clk);
      sclk = 0;
      repeat (3) @(negedge clk);
    end
    sdi = 0;
    frame(24'h10000C, 24, "R10 frame after idle toggles");
    chk("R10 idle toggles ignored", {14'h0, code}, 32'h00003);

    repeat (10) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule